// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block is a watchdog that has no service pin of its own. It listens to a shared two-wire serial bus (clock line and data line), sampling both with the system clock. A host services the watchdog by placing a bus start condition on the bus and then, at some later time, a bus stop condition. When that pair completes, the running period is restarted.

If no such pair arrives before the selected period runs out, the block drives its active-low timeout output low for a fixed pulse time. It also raises a one-cycle event flag, which a fault register can use to record the failure. When the pulse ends, a fresh period begins from zero.

All timing is counted in ticks of an external millisecond strobe. A 2-bit select input chooses one of three periods or turns the watchdog off. By default the periods are 1400, 200 and 25 ticks. The pulse lasts 200 ticks for the two longer periods and 25 ticks for the shortest one.

Top module: `busact_wdt`

## Requirements
- R1: After reset, `wdt_n` is 1, `wdt_evt` is 0 and the period count starts from zero.
- R2: With `per_sel` = 00, 01 and 10, `wdt_n` falls on the tick that completes PER_LONG, PER_MID and PER_SHORT ticks, respectively, with no qualifying restart. It does not fall on any earlier tick.
- R3: The low pulse lasts PULSE_LONG ticks for `per_sel` 00 and 01, and PULSE_SHORT ticks for 10. `wdt_n` returns to 1 on the last tick of the pulse.
- R4: `wdt_evt` is 1 for exactly one clock cycle, in the cycle where `wdt_n` first goes low.
- R5: After a pulse ends, the next timeout comes after a full period counted from zero.
- R6: A start condition (data falls while the clock line is high) that is later followed by a stop condition (data rises while the clock line is high) restarts the period count from zero.
- R7: A stop with no preceding start does not restart the count. A start with no following stop does not restart the count.
- R8: Data-line changes made while the clock line is low are ignored by the watchdog.
- R9: With `per_sel` = 11, `wdt_n` stays 1, `wdt_evt` stays 0 and the count is held at zero.
- R10: Any change of `per_sel` ends a pulse in progress (`wdt_n` back to 1) and restarts the count from zero.
- R11: A qualifying restart that arrives during a pulse is ignored, so the pulse keeps its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle timebase strobe (one tick) |
| bus_scl | input | 1 | Bus clock line, asynchronous |
| bus_sda | input | 1 | Bus data line, asynchronous |
| per_sel | input | 2 | Period select: 00 long, 01 mid, 10 short, 11 off |
| wdt_n | output | 1 | Active-low timeout output, registered |
| wdt_evt | output | 1 | One-cycle pulse when a timeout begins |

## Verification
The bench sweeps all three period codes on a small configuration. For each code it counts ticks to one short of the limit and then to the limit, which tells the three periods and the two pulse widths apart. Bus patterns are applied part way through a period: a complete start-then-stop, a lone stop, a lone start, and data toggling while the clock line is low. Only the complete start-then-stop must move the timeout later. The bench also switches to the disabled code, changes the select in the middle of a pulse, and sends a restart during a pulse, to confirm that the counter is cleared in the first two cases and that the pulse keeps its width in the third.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_PULSE = 1'b1
  } wdt_state_e;

  localparam logic [1:0] SEL_LONG  = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_OFF   = 2'b11;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bus_edge_det.sv
module bus_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  // index 0 = scl, index 1 = sda
  logic [1:0] chain [STAGES];
  logic [1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 2'b11;
        else     chain[g] <= {sda_i, scl_i};
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 2'b11;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 2'b11;
    else     prev_q <= chain[STAGES-1];
  end

  logic scl_s, sda_s, scl_p, sda_p, scl_hi;
  assign scl_s  = chain[STAGES-1][0];
  assign sda_s  = chain[STAGES-1][1];
  assign scl_p  = prev_q[0];
  assign sda_p  = prev_q[1];
  assign scl_hi = scl_s & scl_p;

  assign start_o = scl_hi &  sda_p & ~sda_s;
  assign stop_o  = scl_hi & ~sda_p &  sda_s;
endmodule

// File: rtl/kick_qual.sv
module kick_qual (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  output logic kick_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      kick_o  <= 1'b0;
    end else begin
      kick_o <= stop_i & armed_q;
      if (start_i)     armed_q <= 1'b1;
      else if (stop_i) armed_q <= 1'b0;
    end
  end

  AST_KICK_DISARMS: assert property (@(posedge clk) disable iff (rst)
    kick_o |-> !armed_q); // R6
  AST_STOP_ALONE_NO_KICK: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !armed_q) |=> !kick_o); // R7
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned PER_LONG    = 1400,
  parameter int unsigned PER_MID     = 200,
  parameter int unsigned PER_SHORT   = 25,
  parameter int unsigned PULSE_LONG  = 200,
  parameter int unsigned PULSE_SHORT = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic [1:0] sel_i,
  output logic       wdt_n_o,
  output logic       evt_o
);
  localparam int unsigned MAXV  = max2(max2(PER_LONG, PER_MID), max2(PER_SHORT, PULSE_LONG));
  localparam int unsigned CNT_W = $clog2(MAXV + 1);
  localparam logic [CNT_W-1:0] LIM_L  = CNT_W'(PER_LONG - 1);
  localparam logic [CNT_W-1:0] LIM_M  = CNT_W'(PER_MID - 1);
  localparam logic [CNT_W-1:0] LIM_S  = CNT_W'(PER_SHORT - 1);
  localparam logic [CNT_W-1:0] LIM_PL = CNT_W'(PULSE_LONG - 1);
  localparam logic [CNT_W-1:0] LIM_PS = CNT_W'(PULSE_SHORT - 1);

  wdt_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] per_last, pulse_last;

  always_comb begin
    case (sel_q)
      SEL_LONG:  begin per_last = LIM_L; pulse_last = LIM_PL; end
      SEL_MID:   begin per_last = LIM_M; pulse_last = LIM_PL; end
      SEL_SHORT: begin per_last = LIM_S; pulse_last = LIM_PS; end
      default:   begin per_last = '0;    pulse_last = '0;     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      sel_q   <= sel_i;
      wdt_n_o <= 1'b1;
      evt_o   <= 1'b0;
    end else begin
      sel_q <= sel_i;
      evt_o <= 1'b0;
      if (sel_i == SEL_OFF || sel_i != sel_q) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
        wdt_n_o <= 1'b1;
      end else if (state_q == ST_RUN) begin
        if (kick_i) begin
          cnt_q <= '0;
        end else if (tick_i) begin
          if (cnt_q == per_last) begin
            state_q <= ST_PULSE;
            cnt_q   <= '0;
            wdt_n_o <= 1'b0;
            evt_o   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else if (tick_i) begin
        if (cnt_q == pulse_last) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          wdt_n_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o); // R4
  AST_EVT_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_n_o) |-> evt_o); // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SEL_OFF) |=> (wdt_n_o && !evt_o && cnt_q == '0)); // R9
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (cnt_q <= per_last)); // R2
  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PULSE) |-> !wdt_n_o); // R3
endmodule

// File: rtl/busact_wdt.sv
module busact_wdt #(
  parameter int unsigned PER_LONG    = 1400,
  parameter int unsigned PER_MID     = 200,
  parameter int unsigned PER_SHORT   = 25,
  parameter int unsigned PULSE_LONG  = 200,
  parameter int unsigned PULSE_SHORT = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       bus_scl,
  input  logic       bus_sda,
  input  logic [1:0] per_sel,
  output logic       wdt_n,
  output logic       wdt_evt
);
  logic start_w, stop_w, kick_w;

  bus_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .scl_i(bus_scl), .sda_i(bus_sda),
    .start_o(start_w), .stop_o(stop_w)
  );

  kick_qual qual_i (
    .clk(clk), .rst(rst), .start_i(start_w), .stop_i(stop_w), .kick_o(kick_w)
  );

  wdt_core #(
    .PER_LONG(PER_LONG), .PER_MID(PER_MID), .PER_SHORT(PER_SHORT),
    .PULSE_LONG(PULSE_LONG), .PULSE_SHORT(PULSE_SHORT)
  ) core_i (
    .clk(clk), .rst(rst), .tick_i(ms_tick), .kick_i(kick_w), .sel_i(per_sel),
    .wdt_n_o(wdt_n), .evt_o(wdt_evt)
  );
endmodule

// File: tb/busact_wdt_tb_top.sv
module busact_wdt_tb_top;
  localparam int PL = 14, PM = 6, PS = 3, QL = 4, QS = 2;

  logic clk = 0, rst = 1, ms_tick = 0, bus_scl = 1, bus_sda = 1;
  logic [1:0] per_sel = 2'b00;
  logic wdt_n, wdt_evt;
  int checks = 0, fails = 0, evt_count = 0;
  logic evt_seen;

  always #2 clk = ~clk;

  busact_wdt #(.PER_LONG(PL), .PER_MID(PM), .PER_SHORT(PS),
               .PULSE_LONG(QL), .PULSE_SHORT(QS)) dut_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_scl(bus_scl), .bus_sda(bus_sda),
    .per_sel(per_sel), .wdt_n(wdt_n), .wdt_evt(wdt_evt));

  always @(posedge clk) if (!rst && wdt_evt) evt_count++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick1();
    @(negedge clk) ms_tick = 1;
    @(negedge clk) ms_tick = 0;
    evt_seen = wdt_evt;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic bus_start();
    bus_sda = 1; bus_scl = 1; idle(4);
    bus_sda = 0; idle(4);
    bus_scl = 0; idle(4);
  endtask

  task automatic bus_stop();
    bus_scl = 0; bus_sda = 0; idle(4);
    bus_scl = 1; idle(4);
    bus_sda = 1; idle(6);
  endtask

  task automatic expect_wdt(input logic exp, input string req);
    check(wdt_n === exp, req, int'(wdt_n), int'(exp));
  endtask

  // sweep one period code from a freshly zeroed counter
  task automatic run_code(input int per, input int pw, input string rq);
    ticks(per - 1);
    expect_wdt(1'b1, {"R2 ", rq});
    tick1();
    expect_wdt(1'b0, {"R2 ", rq});
    check(evt_seen === 1'b1, "R4 evt at fall", int'(evt_seen), 1);
    @(negedge clk);
    check(wdt_evt === 1'b0, "R4 evt one cycle", int'(wdt_evt), 0);
    ticks(pw - 1);
    expect_wdt(1'b0, {"R3 ", rq});
    tick1();
    expect_wdt(1'b1, {"R3 ", rq});
    ticks(per - 1);
    expect_wdt(1'b1, {"R5 ", rq});
    tick1();
    expect_wdt(1'b0, {"R5 ", rq});
  endtask

  initial begin
    fork
      begin
        idle(4); rst = 0; @(negedge clk);
        expect_wdt(1'b1, "R1 reset");
        check(wdt_evt === 1'b0, "R1 reset evt", int'(wdt_evt), 0);

        run_code(PL, QL, "sel00");
        per_sel = 2'b01; idle(2);
        expect_wdt(1'b1, "R10 sel change ends pulse");
        run_code(PM, QL, "sel01");
        per_sel = 2'b10; idle(2);
        expect_wdt(1'b1, "R10 sel change ends pulse");
        run_code(PS, QS, "sel10");

        // kick tests on mid period
        per_sel = 2'b01; idle(2);
        ticks(4); bus_start(); bus_stop();
        ticks(PM - 1); expect_wdt(1'b1, "R6 start+stop restarts");
        tick1();       expect_wdt(1'b0, "R6 timeout after restart");
        ticks(QL);     expect_wdt(1'b1, "R3 pulse end");
        ticks(4); bus_stop();
        ticks(1); expect_wdt(1'b1, "R7 lone stop");
        tick1();  expect_wdt(1'b0, "R7 lone stop no restart");
        ticks(QL);
        ticks(3); bus_start();
        ticks(2); expect_wdt(1'b1, "R7 lone start");
        tick1();  expect_wdt(1'b0, "R7 lone start no restart");
        bus_stop(); // qualifying pair completes during the pulse
        ticks(QL - 1); expect_wdt(1'b0, "R11 kick in pulse ignored");
        tick1();       expect_wdt(1'b1, "R11 pulse full width");
        ticks(3);
        bus_scl = 0; idle(3);
        for (int k = 0; k < 4; k++) begin bus_sda = ~bus_sda; idle(3); end
        bus_sda = 1; idle(3); bus_scl = 1; idle(6);
        ticks(2); expect_wdt(1'b1, "R8 data toggles");
        tick1();  expect_wdt(1'b0, "R8 data toggles no restart");

        per_sel = 2'b11; idle(2);
        expect_wdt(1'b1, "R9 off ends pulse");
        evt_count = 0;
        ticks(3 * PL);
        expect_wdt(1'b1, "R9 off stays high");
        check(evt_count == 0, "R9 off no event", evt_count, 0);
        per_sel = 2'b01; idle(2);
        ticks(PM - 1); expect_wdt(1'b1, "R9 count cleared");
        tick1();       expect_wdt(1'b0, "R9 count cleared");
        per_sel = 2'b10; idle(2);
        ticks(1); per_sel = 2'b00; idle(2);
        ticks(PL - 1); expect_wdt(1'b1, "R10 change restarts count");
        tick1();       expect_wdt(1'b0, "R10 change restarts count");
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule